// File: doc/BRIEF.md
# Thermal Sensor Power Sequencer

This block brings an on-chip temperature sensor front end up and down in a fixed, timed order. A mode request (enable or disable) arrives as a one-cycle strobe with a single data bit. The block drives a two-bit control word to the sensor. Bit 0 is the sensor enable and bit 1 is the output enable. Each bit is followed by its own settle interval, and only after both intervals does the block raise a ready flag. Downstream measurement logic waits for that flag before it samples the sensor.

The block keeps the last accepted mode. A request for the mode that is already in force is dropped. A sleep strobe from a power controller turns the sensor off and then holds it in reset. A wake strobe releases that reset. If the kept mode was "enabled", the wake also replays the whole start sequence.

Both settle intervals are set in microseconds. They are turned into cycle counts from the clock frequency parameter, and the counts are rounded up so that neither wait can fall below its minimum.

Top module: `tsense_seq`

## Requirements
- R1: After a synchronous reset the control word is 2'b00, ready and sensor reset are low, and the kept mode is disabled, so a following enable request is accepted.
- R2: Control bit 0 is the sensor enable and bit 1 is the output enable. Bit 1 is never high unless bit 0 is high.
- R3: An accepted enable request sets the control word to 2'b01 from the next cycle on, for exactly T1 = ceil(CLK_HZ*WARM_US/1e6) cycles.
- R4: After the T1 interval the control word is 2'b11 with ready low for exactly T2 = ceil(CLK_HZ*SETTLE_US/1e6) cycles. Ready then goes high.
- R5: An accepted disable request clears both control bits together, one cycle later, and drops ready. This also holds while the start sequence is running, which it aborts.
- R6: A mode request equal to the kept mode has no effect. An enable request during the start sequence neither restarts nor lengthens it.
- R7: A sleep strobe clears the control word and ready in the next cycle. One cycle later the sensor reset is asserted, with the control word still clear. While asleep, mode requests, further sleep strobes are ignored. A wake strobe given when the block is not asleep is also ignored.
- R8: A wake strobe while asleep releases the sensor reset in the next cycle. If the kept mode is enabled, the full R3/R4 sequence runs again. Otherwise the sensor stays off.
- R9: Ready is high only when the control word is 2'b11, the sensor reset is low, and both settle intervals have fully elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req_valid | input | 1 | One-cycle mode request strobe |
| mode_req_enable | input | 1 | Requested mode: 1 enable, 0 disable |
| sleep_req | input | 1 | Strobe: power the sensor down and hold it in reset |
| wake_req | input | 1 | Strobe: release the reset and restore the kept mode |
| sensor_ctl | output | 2 | Bit 0 sensor enable, bit 1 output enable |
| sensor_rst | output | 1 | Sensor reset, active high |
| sensor_ready | output | 1 | Sensor powered and settled |

## Verification
Every state decodes directly to the three outputs, so a wrong state shows at the ports in the cycle after the faulty transition. A wrong interval count shows up when the edge of bit 1 or of ready lands early or late. A lost or corrupted kept mode only appears later: at the next redundant request, which then acts when it should not, or at the next wake, which restores the wrong mode. The bench therefore probes the kept mode after every path that could alter it.

// File: rtl/tsense_pkg.sv
package tsense_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WARM,
        ST_SETTLE,
        ST_ON,
        ST_QUIESCE,
        ST_ASLEEP
    } seq_state_e;

    // Bit positions matter: out_en is bit 1, sens_en is bit 0.
    typedef struct packed {
        logic out_en;
        logic sens_en;
    } ctl_t;

    localparam longint unsigned US_PER_S = 64'd1_000_000;

    // Round up so the wait is never shorter than asked, and never zero.
    function automatic int unsigned us_to_cycles(longint unsigned clk_hz,
                                                 longint unsigned us);
        longint unsigned raw;
        raw = (clk_hz * us + US_PER_S - 64'd1) / US_PER_S;
        if (raw < 64'd1) raw = 64'd1;
        return int'(raw);
    endfunction

endpackage

// File: rtl/tsense_timer.sv
module tsense_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/tsense_fsm.sv
module tsense_fsm
    import tsense_pkg::*;
#(
    parameter int unsigned W      = 8,
    parameter int unsigned T1_CYC = 30,
    parameter int unsigned T2_CYC = 50
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_valid,
    input  logic         req_en,
    input  logic         sleep_req,
    input  logic         wake_req,
    input  logic         expired,
    output logic         load,
    output logic [W-1:0] load_val,
    output seq_state_e   state
);
    localparam logic [W-1:0] T1_LOAD = W'(T1_CYC - 1);
    localparam logic [W-1:0] T2_LOAD = W'(T2_CYC - 1);

    seq_state_e st_q, st_d;
    logic       mode_q, mode_d;
    logic       accept;

    assign accept = req_valid && (req_en != mode_q);

    always_comb begin
        st_d     = st_q;
        mode_d   = mode_q;
        load     = 1'b0;
        load_val = '0;
        case (st_q)
            ST_QUIESCE: st_d = ST_ASLEEP;
            ST_ASLEEP: begin
                if (wake_req) begin
                    if (mode_q) begin
                        st_d     = ST_WARM;
                        load     = 1'b1;
                        load_val = T1_LOAD;
                    end else begin
                        st_d = ST_OFF;
                    end
                end
            end
            default: begin
                if (sleep_req) begin
                    st_d = ST_QUIESCE;
                end else if (accept) begin
                    mode_d = req_en;
                    if (req_en) begin
                        st_d     = ST_WARM;
                        load     = 1'b1;
                        load_val = T1_LOAD;
                    end else begin
                        st_d = ST_OFF;
                    end
                end else begin
                    case (st_q)
                        ST_WARM: if (expired) begin
                            st_d     = ST_SETTLE;
                            load     = 1'b1;
                            load_val = T2_LOAD;
                        end
                        ST_SETTLE: if (expired) st_d = ST_ON;
                        default: ;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_OFF;
            mode_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            mode_q <= mode_d;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/tsense_outdec.sv
module tsense_outdec
    import tsense_pkg::*;
(
    input  seq_state_e state,
    output ctl_t       ctl,
    output logic       sens_rst,
    output logic       ready
);
    always_comb begin
        ctl      = '0;
        sens_rst = 1'b0;
        ready    = 1'b0;
        case (state)
            ST_WARM:   ctl.sens_en = 1'b1;
            ST_SETTLE: begin
                ctl.sens_en = 1'b1;
                ctl.out_en  = 1'b1;
            end
            ST_ON: begin
                ctl.sens_en = 1'b1;
                ctl.out_en  = 1'b1;
                ready       = 1'b1;
            end
            ST_ASLEEP: sens_rst = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/tsense_seq.sv
module tsense_seq
    import tsense_pkg::*;
#(
    parameter longint unsigned CLK_HZ    = 1_000_000,
    parameter longint unsigned WARM_US   = 30,
    parameter longint unsigned SETTLE_US = 50
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_req_valid,
    input  logic       mode_req_enable,
    input  logic       sleep_req,
    input  logic       wake_req,
    output logic [1:0] sensor_ctl,
    output logic       sensor_rst,
    output logic       sensor_ready
);
    localparam int unsigned T1_CYC = us_to_cycles(CLK_HZ, WARM_US);
    localparam int unsigned T2_CYC = us_to_cycles(CLK_HZ, SETTLE_US);
    localparam int unsigned T_MAX  = (T1_CYC > T2_CYC) ? T1_CYC : T2_CYC;
    localparam int unsigned CNT_W  = $clog2(T_MAX + 1);

    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expired;
    seq_state_e       state;
    ctl_t             ctl;

    tsense_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    tsense_fsm #(.W(CNT_W), .T1_CYC(T1_CYC), .T2_CYC(T2_CYC)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (mode_req_valid),
        .req_en    (mode_req_enable),
        .sleep_req (sleep_req),
        .wake_req  (wake_req),
        .expired   (expired),
        .load      (load),
        .load_val  (load_val),
        .state     (state)
    );

    tsense_outdec u_dec (
        .state    (state),
        .ctl      (ctl),
        .sens_rst (sensor_rst),
        .ready    (sensor_ready)
    );

    assign sensor_ctl = ctl;
endmodule

// File: rtl/tsense_seq_chk.sv
module tsense_seq_chk #(
    parameter int unsigned T1_CYC = 30,
    parameter int unsigned T2_CYC = 50
) (
    input logic       clk,
    input logic       rst,
    input logic       mode_req_valid,
    input logic       mode_req_enable,
    input logic       sleep_req,
    input logic [1:0] sensor_ctl,
    input logic       sensor_rst,
    input logic       sensor_ready
);
    logic [31:0] warm_cnt, settle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            warm_cnt   <= '0;
            settle_cnt <= '0;
        end else begin
            warm_cnt   <= (sensor_ctl == 2'b01) ? warm_cnt + 32'd1 : 32'd0;
            settle_cnt <= (sensor_ctl == 2'b11 && !sensor_ready) ? settle_cnt + 32'd1 : 32'd0;
        end
    end

    assert_oe_needs_en_R2: assert property (@(posedge clk) disable iff (rst)
        sensor_ctl[1] |-> sensor_ctl[0]);

    assert_warm_len_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sensor_ctl[1]) |-> warm_cnt == T1_CYC);

    assert_settle_len_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(sensor_ready) |-> settle_cnt == T2_CYC);

    assert_disable_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_req_valid && !mode_req_enable && !sleep_req && !sensor_rst && sensor_ctl != 2'b00)
        |=> (sensor_ctl == 2'b00 && !sensor_ready));

    assert_sleep_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (sleep_req && !sensor_rst) |=> (sensor_ctl == 2'b00 && !sensor_ready));

    assert_reset_after_off_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(sensor_rst) |-> $past(sensor_ctl) == 2'b00);

    assert_reset_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        sensor_rst |-> (sensor_ctl == 2'b00 && !sensor_ready));

    assert_ready_settled_R9: assert property (@(posedge clk) disable iff (rst)
        sensor_ready |-> (sensor_ctl == 2'b11 && !sensor_rst));
endmodule

bind tsense_seq tsense_seq_chk #(.T1_CYC(T1_CYC), .T2_CYC(T2_CYC)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .mode_req_valid  (mode_req_valid),
    .mode_req_enable (mode_req_enable),
    .sleep_req       (sleep_req),
    .sensor_ctl      (sensor_ctl),
    .sensor_rst      (sensor_rst),
    .sensor_ready    (sensor_ready)
);

// File: tb/sim_tsense_seq.sv
module sim_tsense_seq;
    localparam int CLK_PERIOD = 10;
    localparam longint unsigned CLK_HZ = 333_333;
    // Expected intervals computed from the rounding rule of R3/R4.
    localparam int E1 = int'((CLK_HZ * 30 + 999_999) / 1_000_000);
    localparam int E2 = int'((CLK_HZ * 50 + 999_999) / 1_000_000);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_req_valid = 1'b0, mode_req_enable = 1'b0;
    logic sleep_req = 1'b0, wake_req = 1'b0;
    logic [1:0] sensor_ctl;
    logic sensor_rst, sensor_ready;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsense_seq #(.CLK_HZ(CLK_HZ), .WARM_US(30), .SETTLE_US(50)) u0 (
        .clk             (clk),
        .rst             (rst),
        .mode_req_valid  (mode_req_valid),
        .mode_req_enable (mode_req_enable),
        .sleep_req       (sleep_req),
        .wake_req        (wake_req),
        .sensor_ctl      (sensor_ctl),
        .sensor_rst      (sensor_rst),
        .sensor_ready    (sensor_ready)
    );

    task automatic chk(string req, logic [1:0] ec, logic er, logic ey);
        checks++;
        if (sensor_ctl !== ec || sensor_rst !== er || sensor_ready !== ey) begin
            errs++;
            $display("FAIL %s t=%0t: ctl/rst/rdy actual %b/%b/%b expected %b/%b/%b",
                     req, $time, sensor_ctl, sensor_rst, sensor_ready, ec, er, ey);
        end
    endtask

    task automatic clear_pulses();
        mode_req_valid = 1'b0;
        sleep_req      = 1'b0;
        wake_req       = 1'b0;
    endtask

    task automatic hold(int n, logic [1:0] ec, logic er, logic ey, string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(req, ec, er, ey);
            clear_pulses();
        end
    endtask

    task automatic req(logic en);
        mode_req_valid  = 1'b1;
        mode_req_enable = en;
    endtask

    // Full start sequence check; optionally re-issues an enable at cycle repulse.
    task automatic check_start(int repulse, string tag);
        for (int i = 0; i < E1 + E2 + 2; i++) begin
            @(negedge clk);
            if (i < E1)            chk(tag, 2'b01, 1'b0, 1'b0);
            else if (i < E1 + E2)  chk(tag, 2'b11, 1'b0, 1'b0);
            else                   chk(tag, 2'b11, 1'b0, 1'b1);
            clear_pulses();
            if (i == repulse) req(1'b1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        hold(2, 2'b00, 1'b0, 1'b0, "R1");

        // Redundant disable while off
        req(1'b0);
        hold(5, 2'b00, 1'b0, 1'b0, "R6");

        // Normal start, then steady ready
        req(1'b1);
        check_start(-1, "R3_R4");
        hold(5, 2'b11, 1'b0, 1'b1, "R9");

        // Redundant enable while on
        req(1'b1);
        hold(5, 2'b11, 1'b0, 1'b1, "R6");

        // Disable
        req(1'b0);
        hold(3, 2'b00, 1'b0, 1'b0, "R5");

        // Abort during first interval
        req(1'b1);
        hold(3, 2'b01, 1'b0, 1'b0, "R3");
        req(1'b0);
        hold(3, 2'b00, 1'b0, 1'b0, "R5");

        // Abort during second interval
        req(1'b1);
        hold(E1, 2'b01, 1'b0, 1'b0, "R3");
        hold(4, 2'b11, 1'b0, 1'b0, "R4");
        req(1'b0);
        hold(2, 2'b00, 1'b0, 1'b0, "R5");

        // Enable during start does not restart it
        req(1'b1);
        check_start(4, "R6");

        // Sleep from on; requests ignored while asleep; wake restores
        sleep_req = 1'b1;
        hold(1, 2'b00, 1'b0, 1'b0, "R7");
        hold(4, 2'b00, 1'b1, 1'b0, "R7");
        req(1'b0);
        hold(3, 2'b00, 1'b1, 1'b0, "R7");
        sleep_req = 1'b1;
        hold(2, 2'b00, 1'b1, 1'b0, "R7");
        wake_req = 1'b1;
        check_start(-1, "R8");

        // Sleep during first interval, wake restores enabled
        req(1'b0);
        hold(1, 2'b00, 1'b0, 1'b0, "R5");
        req(1'b1);
        hold(2, 2'b01, 1'b0, 1'b0, "R3");
        sleep_req = 1'b1;
        hold(1, 2'b00, 1'b0, 1'b0, "R7");
        hold(2, 2'b00, 1'b1, 1'b0, "R7");
        wake_req = 1'b1;
        check_start(-1, "R8");

        // Sleep from off, wake keeps it off
        req(1'b0);
        hold(1, 2'b00, 1'b0, 1'b0, "R5");
        sleep_req = 1'b1;
        hold(1, 2'b00, 1'b0, 1'b0, "R7");
        hold(2, 2'b00, 1'b1, 1'b0, "R7");
        wake_req = 1'b1;
        hold(6, 2'b00, 1'b0, 1'b0, "R8");

        // Stray wake while not asleep is ignored
        wake_req = 1'b1;
        hold(3, 2'b00, 1'b0, 1'b0, "R7");

        // Reset while on clears kept mode: enable accepted afterwards
        req(1'b1);
        check_start(-1, "R3");
        rst = 1'b1;
        hold(1, 2'b00, 1'b0, 1'b0, "R1");
        rst = 1'b0;
        hold(2, 2'b00, 1'b0, 1'b0, "R1");
        req(1'b1);
        check_start(-1, "R1");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule